// File: doc/BRIEF.md
# Power-of-Two Oversampling Averager

This block takes signed conversion results from a converter, one at a time, and adds 2^N of them into a wide accumulator. When the last one of a group arrives it emits the group's mean as one 16-bit result. The shift N can be any value from 0 to 8, so a group holds between 1 and 256 conversions. Two event pulses leave the block. The per-conversion pulse marks every accepted input. The per-average pulse marks each finished mean that the result writer downstream should store.

The block owns the request line to the converter and keeps at most one conversion outstanding. In the single-step mode, each sample trigger asks for one conversion, so 2^N triggers produce one average. In the burst mode, one trigger starts a chain: the next conversion is requested as soon as the previous result is taken, and the chain ends when the group is complete. The start command loads the shift and the mode, clears partial sums, and enables the block. The stop command clears the same state and disables the block until the next start.

Top module: `ovs_averager`

## Requirements
- R1: After reset the request, per-conversion and per-average outputs are low and the result output is zero. The block ignores triggers until the first start.
- R2: The shift and burst inputs are captured only on a start pulse. Changing them between starts has no effect on grouping or mode.
- R3: In single-step mode an accepted trigger raises the conversion request for one cycle, in the cycle that follows the trigger. A trigger is ignored while a conversion is outstanding, and also while the block is stopped.
- R4: The per-conversion pulse is high in the cycle after each accepted result. A result that arrives with no conversion outstanding is ignored.
- R5: After 2^N accepted results, the per-average pulse is high in the same cycle as the final per-conversion pulse. The result equals the sum of the group divided by 2^N and rounded toward negative infinity, in 16-bit two's complement. Full-scale groups of 256 do not overflow.
- R6: With N = 0 every per-conversion pulse comes with a per-average pulse, and the result equals the input value.
- R7: In burst mode one trigger produces exactly 2^N requests. Each request after the first is raised in the cycle after the previous result is accepted. Triggers that arrive during the chain are ignored.
- R8: A start or stop pulse clears the partial sum, the group count and any outstanding conversion. A result that arrives later for that conversion is dropped. If start and stop arrive in the same cycle, stop wins.
- R9: A captured shift above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture configuration, clear state, enable |
| stop_i | input | 1 | Clear state, disable |
| os_shift_i | input | 4 | Oversampling shift N (group is 2^N) |
| burst_en_i | input | 1 | 1 selects burst mode |
| sample_trig_i | input | 1 | Sample trigger |
| conv_req_o | output | 1 | Request one conversion (one-cycle pulse) |
| conv_valid_i | input | 1 | Conversion result valid |
| conv_data_i | input | 16 | Signed conversion result |
| done_o | output | 1 | Per-conversion pulse |
| result_valid_o | output | 1 | Per-average pulse |
| result_o | output | 16 | Signed average, held until the next average |

## Verification
The assertions assume that the converter returns at most one result for each request, and that configuration changes are applied only through start. They do not depend on a fixed converter latency. The bench's converter model replies exactly once, two cycles after it sees a request. The stray-result and stop tests inject results outside this pattern on purpose, and they check only that such results are dropped. The bench changes the shift and mode inputs only around start pulses, except in the one test where it changes them on purpose to show that they are ignored.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  localparam int OVS_DATA_W    = 16;
  localparam int OVS_MAX_SHIFT = 8;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_IDLE   = 2'd1,
    ST_SINGLE = 2'd2,
    ST_BURST  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/ovs_cfg.sv
module ovs_cfg #(
  parameter int MAX_SHIFT = 8,
  parameter int SH_W      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic [SH_W-1:0] os_i,
  input  logic            burst_i,
  output logic [SH_W-1:0] os_o,
  output logic            burst_o
);
  localparam logic [SH_W-1:0] SH_CAP = SH_W'(MAX_SHIFT);

  function automatic logic [SH_W-1:0] clamp_shift(input logic [SH_W-1:0] v);
    return (v > SH_CAP) ? SH_CAP : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_o    <= '0;
      burst_o <= 1'b0;
    end else if (start_i && !stop_i) begin
      os_o    <= clamp_shift(os_i);
      burst_o <= burst_i;
    end
  end
endmodule

// File: rtl/ovs_seq.sv
module ovs_seq
  import ovs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic trig_i,
  input  logic burst_i,
  input  logic conv_valid_i,
  input  logic avg_last_i,
  output logic conv_req_o,
  output logic accept_o,
  output logic pend_o,
  output logic run_o
);
  seq_st_e st_q, st_d;
  logic    req_d;

  assign pend_o   = (st_q == ST_SINGLE) || (st_q == ST_BURST);
  assign run_o    = (st_q != ST_OFF);
  assign accept_o = pend_o && conv_valid_i && !start_i && !stop_i;

  always_comb begin
    st_d  = st_q;
    req_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (trig_i) begin
          req_d = 1'b1;
          st_d  = burst_i ? ST_BURST : ST_SINGLE;
        end
      end
      ST_SINGLE: begin
        if (accept_o) st_d = ST_IDLE;
      end
      ST_BURST: begin
        if (accept_o) begin
          if (avg_last_i) st_d = ST_IDLE;
          else            req_d = 1'b1;
        end
      end
      default: st_d = ST_OFF;
    endcase
    if (stop_i) begin
      st_d  = ST_OFF;
      req_d = 1'b0;
    end else if (start_i) begin
      st_d  = ST_IDLE;
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_OFF;
      conv_req_o <= 1'b0;
    end else begin
      st_q       <= st_d;
      conv_req_o <= req_d;
    end
  end
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum #(
  parameter int DATA_W    = 16,
  parameter int MAX_SHIFT = 8,
  parameter int SH_W      = 4,
  parameter int CNT_W     = MAX_SHIFT + 1,
  parameter int ACC_W     = DATA_W + MAX_SHIFT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     accept_i,
  input  logic signed [DATA_W-1:0] data_i,
  input  logic [SH_W-1:0]          shift_i,
  output logic                     avg_last_o,
  output logic [CNT_W-1:0]         cnt_o,
  output logic                     done_o,
  output logic                     res_valid_o,
  output logic signed [DATA_W-1:0] res_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic signed [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0]        cnt_q;
  logic signed [ACC_W-1:0] sum_w;

  function automatic logic [CNT_W-1:0] group_last(input logic [SH_W-1:0] sh);
    return (CNT_ONE << sh) - CNT_ONE;
  endfunction

  function automatic logic signed [ACC_W-1:0] widen(input logic signed [DATA_W-1:0] v);
    return {{(ACC_W-DATA_W){v[DATA_W-1]}}, v};
  endfunction

  function automatic logic signed [DATA_W-1:0] mean_of(input logic signed [ACC_W-1:0] s,
                                                       input logic [SH_W-1:0] sh);
    logic signed [ACC_W-1:0] q;
    q = s >>> sh;
    return q[DATA_W-1:0];
  endfunction

  assign sum_w      = acc_q + widen(data_i);
  assign avg_last_o = (cnt_q == group_last(shift_i));
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      cnt_q       <= '0;
      done_o      <= 1'b0;
      res_valid_o <= 1'b0;
      res_o       <= '0;
    end else if (clr_i) begin
      acc_q       <= '0;
      cnt_q       <= '0;
      done_o      <= 1'b0;
      res_valid_o <= 1'b0;
    end else begin
      done_o      <= accept_i;
      res_valid_o <= 1'b0;
      if (accept_i) begin
        if (avg_last_o) begin
          res_o       <= mean_of(sum_w, shift_i);
          res_valid_o <= 1'b1;
          acc_q       <= '0;
          cnt_q       <= '0;
        end else begin
          acc_q <= sum_w;
          cnt_q <= cnt_q + CNT_ONE;
        end
      end
    end
  end
endmodule

// File: rtl/ovs_averager.sv
module ovs_averager
  import ovs_pkg::*;
#(
  parameter int DATA_W    = OVS_DATA_W,
  parameter int MAX_SHIFT = OVS_MAX_SHIFT,
  parameter int SH_W      = $clog2(MAX_SHIFT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [SH_W-1:0]   os_shift_i,
  input  logic              burst_en_i,
  input  logic              sample_trig_i,
  output logic              conv_req_o,
  input  logic              conv_valid_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              done_o,
  output logic              result_valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int CNT_W = MAX_SHIFT + 1;
  localparam int ACC_W = DATA_W + MAX_SHIFT;

  logic [SH_W-1:0]  os_w;
  logic             burst_w;
  logic             accept_w;
  logic             pend_w;
  logic             run_w;
  logic             last_w;
  logic [CNT_W-1:0] cnt_w;
  logic             clr_w;

  assign clr_w = start_i | stop_i;

  ovs_cfg #(.MAX_SHIFT(MAX_SHIFT), .SH_W(SH_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .os_i(os_shift_i), .burst_i(burst_en_i), .os_o(os_w), .burst_o(burst_w)
  );

  ovs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .trig_i(sample_trig_i), .burst_i(burst_w), .conv_valid_i(conv_valid_i),
    .avg_last_i(last_w), .conv_req_o(conv_req_o), .accept_o(accept_w),
    .pend_o(pend_w), .run_o(run_w)
  );

  ovs_accum #(
    .DATA_W(DATA_W), .MAX_SHIFT(MAX_SHIFT), .SH_W(SH_W),
    .CNT_W(CNT_W), .ACC_W(ACC_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_w), .accept_i(accept_w),
    .data_i(conv_data_i), .shift_i(os_w), .avg_last_o(last_w),
    .cnt_o(cnt_w), .done_o(done_o), .res_valid_o(result_valid_o),
    .res_o(result_o)
  );
endmodule

// File: rtl/ovs_averager_chk.sv
module ovs_averager_chk #(
  parameter int MAX_SHIFT = 8,
  parameter int SH_W      = 4,
  parameter int CNT_W     = MAX_SHIFT + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             stop_i,
  input logic             conv_req_o,
  input logic             done_o,
  input logic             result_valid_o,
  input logic             pend,
  input logic             run,
  input logic             accept,
  input logic [SH_W-1:0]  os,
  input logic [CNT_W-1:0] cnt
);
  // R5
  res_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> done_o);
  // R6
  bypass_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (os == '0) && done_o |-> result_valid_o);
  // R3
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !accept |=> !conv_req_o);
  // R3
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !start_i |=> !conv_req_o);
  // R4
  stray_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> !done_o);
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || stop_i) |=> (cnt == '0) && !pend && !done_o);
  // R8
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !run);
  // R9
  shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(os) <= MAX_SHIFT);
  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < (1 << int'(os)));
endmodule

bind ovs_averager ovs_averager_chk #(
  .MAX_SHIFT(MAX_SHIFT), .SH_W(SH_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
  .conv_req_o(conv_req_o), .done_o(done_o), .result_valid_o(result_valid_o),
  .pend(pend_w), .run(run_w), .accept(accept_w), .os(os_w), .cnt(cnt_w)
);

// File: tb/tb_ovs_averager.sv
module tb_ovs_averager;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0;
  logic [3:0]  os_shift_i = '0;
  logic        burst_en_i = 1'b0;
  logic        sample_trig_i = 1'b0;
  logic        conv_req_o, conv_valid_i, done_o, result_valid_o;
  logic [15:0] conv_data_i, result_o;

  logic        mdl_v = 1'b0, stray_v = 1'b0;
  logic [15:0] mdl_d = '0, stray_d = '0;
  int          mdl_cd = 0;
  int          idx = 0, idx_base = 0;
  logic signed [15:0] samp [0:255];

  int mon_done = 0, mon_res = 0, mon_req = 0;
  logic signed [15:0] last_res = '0;
  int checks = 0, failures = 0;

  assign conv_valid_i = mdl_v | stray_v;
  assign conv_data_i  = stray_v ? stray_d : mdl_d;

  always #2.5 clk = ~clk;

  ovs_averager dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .os_shift_i(os_shift_i), .burst_en_i(burst_en_i),
    .sample_trig_i(sample_trig_i), .conv_req_o(conv_req_o),
    .conv_valid_i(conv_valid_i), .conv_data_i(conv_data_i),
    .done_o(done_o), .result_valid_o(result_valid_o), .result_o(result_o)
  );

  // converter model: replies once, two cycles after it sees a request
  always @(negedge clk) begin
    if (mdl_cd == 1) begin
      mdl_v  = 1'b1;
      mdl_d  = samp[(idx - idx_base) & 255];
      idx    = idx + 1;
      mdl_cd = 0;
    end else begin
      mdl_v = 1'b0;
    end
    if (rst_n && conv_req_o) mdl_cd = 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) mon_done = mon_done + 1;
      if (conv_req_o) mon_req = mon_req + 1;
      if (result_valid_o) begin
        mon_res  = mon_res + 1;
        last_res = result_o;
      end
    end
  end

  typedef struct packed {
    logic [3:0]         n;
    logic               burst;
    logic signed [15:0] base;
    logic signed [15:0] step;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b0, 16'sd1234,  16'sd0},
    '{4'd0,  1'b0, -16'sd5,    16'sd0},
    '{4'd1,  1'b0, 16'sd3,     16'sd2},
    '{4'd2,  1'b0, -16'sd3,    16'sd1},
    '{4'd3,  1'b1, 16'sd100,   -16'sd7},
    '{4'd4,  1'b1, -16'sd32768, 16'sd0},
    '{4'd8,  1'b1, 16'sd32767, 16'sd0},
    '{4'd8,  1'b1, -16'sd32768, 16'sd0},
    '{4'd5,  1'b0, -16'sd1000, 16'sd61},
    '{4'd8,  1'b0, -16'sd1000, 16'sd7},
    '{4'd12, 1'b1, -16'sd3,    16'sd0}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_start(input logic [3:0] n, input logic b);
    @(negedge clk);
    os_shift_i = n; burst_en_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic pulse_trig(input int len);
    @(negedge clk);
    sample_trig_i = 1'b1;
    cyc(len);
    sample_trig_i = 1'b0;
  endtask

  task automatic wait_done(input int target, input int lim);
    for (int k = 0; k < lim; k++) begin
      if (mon_done >= target) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_res(input int target, input int lim);
    for (int k = 0; k < lim; k++) begin
      if (mon_res >= target) break;
      @(negedge clk);
    end
  endtask

  function automatic longint floor_mean(input longint s, input int n);
    longint d, q;
    d = longint'(1) << n;
    q = s / d;
    if ((s % d) != 0 && s < 0) q = q - 1;
    return q;
  endfunction

  task automatic run_vec(input vec_t v);
    int n_eff, cnt, d0, r0, q0;
    longint sum;
    string tag;
    n_eff = (v.n > 8) ? 8 : int'(v.n);
    cnt = 1 << n_eff;
    sum = 0;
    for (int i = 0; i < cnt; i++) begin
      int val;
      val = int'(v.base) + i * int'(v.step);
      samp[i] = 16'(val);
      sum += val;
    end
    pulse_start(v.n, v.burst);
    idx_base = idx;
    d0 = mon_done; r0 = mon_res; q0 = mon_req;
    if (v.burst) begin
      pulse_trig(1);
      wait_res(r0 + 1, 4 * cnt + 50);
    end else begin
      for (int i = 0; i < cnt; i++) begin
        pulse_trig(1);
        wait_done(d0 + i + 1, 50);
      end
    end
    cyc(4);
    tag = (v.n > 8) ? "R9" : (v.n == 0) ? "R6" : "R5";
    chk(v.burst ? "R7 request count" : "R3 request count", mon_req - q0, cnt);
    chk("R4 done count", mon_done - d0, cnt);
    chk("R5 average count", mon_res - r0, 1);
    chk({tag, " average value"}, longint'(last_res), floor_mean(sum, n_eff));
  endtask

  initial begin
    cyc(100000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int d0, r0, q0;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", conv_req_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 result_valid", result_valid_o, 0);
    chk("R1 result", result_o, 0);
    // R1 / R3 trigger before first start ignored
    pulse_trig(2);
    cyc(5);
    chk("R1 trigger before start", mon_req, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R4 stray result with nothing outstanding
    pulse_start(4'd0, 1'b0);
    d0 = mon_done; r0 = mon_res;
    @(negedge clk);
    stray_d = 16'sd999; stray_v = 1'b1;
    @(negedge clk);
    stray_v = 1'b0;
    cyc(3);
    chk("R4 stray done", mon_done - d0, 0);
    chk("R4 stray result", mon_res - r0, 0);

    // R3 trigger held while outstanding -> one request
    pulse_start(4'd1, 1'b0);
    idx_base = idx; samp[0] = 16'sd10; samp[1] = 16'sd20;
    q0 = mon_req; d0 = mon_done;
    pulse_trig(3);
    cyc(4);
    chk("R3 trigger while pending", mon_req - q0, 1);
    chk("R3 one done", mon_done - d0, 1);

    // R8 restart mid-average discards partial sum
    pulse_start(4'd1, 1'b0);
    idx_base = idx; samp[0] = 16'sd2; samp[1] = 16'sd4;
    r0 = mon_res; d0 = mon_done;
    pulse_trig(1); wait_done(d0 + 1, 50);
    pulse_trig(1); wait_done(d0 + 2, 50);
    cyc(3);
    chk("R8 restart count", mon_res - r0, 1);
    chk("R8 restart value", longint'(last_res), 3);

    // R7 triggers during a burst ignored
    pulse_start(4'd2, 1'b1);
    idx_base = idx;
    for (int i = 0; i < 4; i++) samp[i] = 16'(i * 4);
    q0 = mon_req; r0 = mon_res;
    pulse_trig(4);
    wait_res(r0 + 1, 100);
    cyc(4);
    chk("R7 burst requests", mon_req - q0, 4);
    chk("R7 burst result", longint'(last_res), 6);

    // R2 config change without start ignored (still N=2 burst)
    @(negedge clk);
    os_shift_i = 4'd0; burst_en_i = 1'b0;
    idx_base = idx;
    for (int i = 0; i < 4; i++) samp[i] = -16'sd8;
    q0 = mon_req; r0 = mon_res;
    pulse_trig(1);
    wait_res(r0 + 1, 100);
    cyc(4);
    chk("R2 captured mode kept", mon_req - q0, 4);
    chk("R2 captured shift value", longint'(last_res), -8);

    // R8 stop mid-burst
    pulse_start(4'd3, 1'b1);
    idx_base = idx;
    for (int i = 0; i < 8; i++) samp[i] = 16'sd50;
    d0 = mon_done; r0 = mon_res;
    pulse_trig(1);
    wait_done(d0 + 2, 50);
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    q0 = mon_req; d0 = mon_done;
    cyc(10);
    chk("R8 no request after stop", mon_req - q0, 0);
    chk("R8 late result dropped", mon_done - d0, 0);
    chk("R8 no average after stop", mon_res - r0, 0);
    pulse_trig(1);
    cyc(5);
    chk("R3 trigger while stopped", mon_req - q0, 0);

    // R8 start and stop together: stop wins
    @(negedge clk); os_shift_i = 4'd0; start_i = 1'b1; stop_i = 1'b1;
    @(negedge clk); start_i = 1'b0; stop_i = 1'b0;
    pulse_trig(1);
    cyc(5);
    chk("R8 stop wins", mon_req - q0, 0);

    summary();
  end
endmodule